// File: doc/BRIEF.md
# Compute Array Ingress Queues

This block stands between a processor pipeline and a circuit-switched compute array. The pipeline hands it values, each tagged with the array port it is meant for. The block keeps one small queue per port and offers the oldest entry of each queue to the array. The value moves only when the array returns a credit for that port. A value can be a register operand, which is ready at once. It can also be a load result, which holds its queue slot as "busy" until the cache returns the data. In both cases the order of issue is kept on each port.

A squash does not flush the queues. It turns every queued entry into a ready entry marked "kill", so the array consumes them and drains in the normal way. It also marks every invocation then in flight, so that the completions of those invocations are flagged for discard. The block counts committed invocations that have not yet completed and grants a reconfiguration only when that count is zero.

Top module: `array_ingress`

## Requirements
- R1: A push with `push_valid`=1 enters only the queue of the port named by `push_dest`, as the newest entry. The value is {switch index, side}, with the side in the two low bits, and it is taken as a flat port index. A register push (`push_mem`=0) is ready at once.
- R2: On each port, entries leave the queue in the order they were pushed.
- R3: A memory push (`push_mem`=1) takes a slot marked busy. While the head entry of a port is busy, `inj_valid` for that port stays 0.
- R4: A fill (`fill_valid`=1) writes `fill_data` into the oldest busy entry of port `fill_dest` and makes it ready. Later busy entries on that port stay busy.
- R5: `inj_valid[p]` is 1 when port p has a ready head entry, and `inj_data` carries that entry. The entry is removed at the clock edge where `inj_valid[p]` and `credit[p]` are both 1.
- R6: A port holding DEPTH entries drives `push_ready[p]`=0. A push to it is dropped and leaves its contents unchanged.
- R7: After a squash, every entry queued before it is ready and leaves with `inj_kill`=1. A fill in the squash cycle is ignored, and so is a fill to a port with no busy entry. A push in the squash cycle is kept as a normal entry.
- R8: `commit` is accepted when fewer than MAX_INV invocations are in flight, and `commit_ready` shows this. `done` retires one invocation and is ignored when none is in flight.
- R9: `cfg_grant` is 1 only when `cfg_req` is 1 and no invocation is in flight.
- R10: A `done` for an invocation that was in flight at a squash (this includes a commit taken in the squash cycle) drives `done_discard`=1 in that cycle. Later invocations complete with `done_discard`=0.
- R11: After reset, all queues are empty, every `push_ready` bit is 1, every `inj_valid` bit is 0, and no invocation is in flight.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | A value is offered this cycle |
| push_dest | input | DESTW | Destination port tag |
| push_mem | input | 1 | 1 = memory-sourced (slot reserved busy) |
| push_data | input | DW | Register value (ignored when push_mem=1) |
| push_ready | output | NPORTS | Per-port room available |
| fill_valid | input | 1 | Load data returned this cycle |
| fill_dest | input | DESTW | Port the load data belongs to |
| fill_data | input | DW | Returned load data |
| squash | input | 1 | Squash everything queued and in flight |
| credit | input | NPORTS | Array accepts one value on each set port |
| inj_valid | output | NPORTS | Ready head entry offered per port |
| inj_kill | output | NPORTS | Offered entry is squashed |
| inj_data | output | NPORTS*DW | Head values, port p at bits p*DW upward |
| commit | input | 1 | Start a new invocation |
| commit_ready | output | 1 | An invocation slot is free |
| done | input | 1 | Array reports one invocation complete |
| done_discard | output | 1 | The completing invocation was squashed |
| cfg_req | input | 1 | Reconfiguration requested |
| cfg_grant | output | 1 | Reconfiguration may proceed |

## Verification
The hardest state to reach is a port whose queue holds, in one window, busy load entries mixed with ready register entries, so that a squash or a fill lands on them while the array withholds credit. The directed part of the stimulus builds this state on purpose. It interleaves memory and register pushes on one port with credit held low, then returns the fills one at a time. It squashes while fills are still owed, and it fills a port with no busy entry. The random part then weights credits, fills and pushes so that queues often fill to capacity and busy heads block them. It also commits past the invocation limit.

// File: rtl/array_ingress_pkg.sv
// Shared types for the compute array ingress block.
// Assumes: nothing beyond IEEE 1800-2017.
package array_ingress_pkg;

    // Per-slot status: busy = waiting for load data, kill = squashed.
    typedef struct packed {
        logic busy;
        logic kill;
    } slot_flags_t;

endpackage

// File: rtl/ingress_port_queue.sv
// One port's ingress queue: a ring buffer of DEPTH slots. A slot is busy
// from a memory push until its fill arrives. A fill goes to the oldest
// busy slot. The head is offered when it is not busy and leaves on credit.
// Assumes DEPTH is a power of two and at most one push and one fill a cycle.
module ingress_port_queue
    import array_ingress_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          push_mem,
    input  logic [DW-1:0] push_data,
    input  logic          fill_en,
    input  logic [DW-1:0] fill_data,
    input  logic          squash,
    input  logic          credit,
    output logic          inj_valid,
    output logic          inj_kill,
    output logic [DW-1:0] inj_data,
    output logic          not_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    slot_flags_t   flg [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          push_acc, pop, fill_hit;
    logic [AW-1:0] fill_idx, scan_idx;
    logic [DEPTH-1:0] occ, busy_vec;

    assign not_full  = (count < CW'(DEPTH));
    assign push_acc  = push_en && not_full;
    assign inj_valid = (count != '0) && !flg[rd_ptr].busy;
    assign inj_kill  = flg[rd_ptr].kill;
    assign inj_data  = mem[rd_ptr];
    assign pop       = inj_valid && credit;

    // Find the oldest busy slot, scanning from the head.
    always_comb begin
        fill_hit = 1'b0;
        fill_idx = rd_ptr;
        scan_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            scan_idx = rd_ptr + AW'(i);
            if (!fill_hit && (CW'(i) < count) && flg[scan_idx].busy) begin
                fill_hit = 1'b1;
                fill_idx = scan_idx;
            end
        end
    end

    // Mark which slots are occupied, and which are busy.
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            occ[j]      = (CW'(AW'(AW'(j) - rd_ptr)) < count);
            busy_vec[j] = occ[j] && flg[j].busy;
        end
    end

    // Pointers, occupancy and slot flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int j = 0; j < DEPTH; j++) flg[j] <= '0;
        end else begin
            if (squash) begin
                for (int j = 0; j < DEPTH; j++)
                    if (occ[j]) flg[j] <= '{busy: 1'b0, kill: 1'b1};
            end else if (fill_en && fill_hit) begin
                flg[fill_idx].busy <= 1'b0;
            end
            if (push_acc) begin
                flg[wr_ptr] <= '{busy: push_mem, kill: 1'b0};
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_acc) - CW'(pop);
        end
    end

    // Slot payloads: register values on push, load data on fill.
    always_ff @(posedge clk) begin
        if (fill_en && !squash && fill_hit) mem[fill_idx] <= fill_data;
        if (push_acc) mem[wr_ptr] <= push_mem ? '0 : push_data;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_full && push_en && !credit) |=> (count == CW'(DEPTH)));
    // R5
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && credit && !push_en) |=> (count == $past(count) - 1'b1));
    // R7
    squash_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && !(push_en && push_mem)) |=> (busy_vec == '0));
endmodule

// File: rtl/invocation_tracker.sv
// Counts committed invocations that have not completed, up to MAX_INV.
// Holds how many of them were in flight at the last squash, so that their
// completions can be flagged for discard. Completions arrive in commit order.
module invocation_tracker #(
    parameter int MAX_INV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic done,
    input  logic squash,
    input  logic cfg_req,
    output logic commit_ready,
    output logic done_discard,
    output logic cfg_grant
);
    localparam int NW = $clog2(MAX_INV + 1);

    logic [NW-1:0] inflight, abort_left, next_inflight;
    logic          commit_acc, done_eff;

    assign commit_ready  = (inflight < NW'(MAX_INV));
    assign commit_acc    = commit && commit_ready;
    assign done_eff      = done && (inflight != '0);
    assign done_discard  = done_eff && (abort_left != '0);
    assign cfg_grant     = cfg_req && (inflight == '0);
    assign next_inflight = inflight + NW'(commit_acc) - NW'(done_eff);

    // In-flight count and the number still owed a discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight   <= '0;
            abort_left <= '0;
        end else begin
            inflight <= next_inflight;
            if (squash)            abort_left <= next_inflight;
            else if (done_discard) abort_left <= abort_left - 1'b1;
        end
    end

    // R8
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= NW'(MAX_INV));
    // R10
    abort_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_left <= inflight);
    // R8
    commit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_ready && !done) |=> (inflight == $past(inflight) + 1'b1));
    // R9
    cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_grant |-> !done_discard && commit_ready);
endmodule

// File: rtl/array_ingress.sv
// Ingress side of a circuit-switched compute array. It steers tagged values
// into per-port queues and offers each head to the array under credit. It
// also tracks invocations for configuration gating and squash discard.
// Assumes push_dest and fill_dest are below NPORTS.
module array_ingress #(
    parameter int NPORTS  = 4,
    parameter int DEPTH   = 8,
    parameter int DW      = 16,
    parameter int MAX_INV = 8,
    localparam int DESTW  = $clog2(NPORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_valid,
    input  logic [DESTW-1:0]     push_dest,
    input  logic                 push_mem,
    input  logic [DW-1:0]        push_data,
    output logic [NPORTS-1:0]    push_ready,
    input  logic                 fill_valid,
    input  logic [DESTW-1:0]     fill_dest,
    input  logic [DW-1:0]        fill_data,
    input  logic                 squash,
    input  logic [NPORTS-1:0]    credit,
    output logic [NPORTS-1:0]    inj_valid,
    output logic [NPORTS-1:0]    inj_kill,
    output logic [NPORTS*DW-1:0] inj_data,
    input  logic                 commit,
    output logic                 commit_ready,
    input  logic                 done,
    output logic                 done_discard,
    input  logic                 cfg_req,
    output logic                 cfg_grant
);
    // One queue per destination port; the tag alone selects it.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        ingress_port_queue #(.DEPTH(DEPTH), .DW(DW)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_en  (push_valid && (push_dest == DESTW'(p))),
            .push_mem (push_mem),
            .push_data(push_data),
            .fill_en  (fill_valid && (fill_dest == DESTW'(p))),
            .fill_data(fill_data),
            .squash   (squash),
            .credit   (credit[p]),
            .inj_valid(inj_valid[p]),
            .inj_kill (inj_kill[p]),
            .inj_data (inj_data[p*DW +: DW]),
            .not_full (push_ready[p])
        );
    end

    invocation_tracker #(.MAX_INV(MAX_INV)) u_inv (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .done        (done),
        .squash      (squash),
        .cfg_req     (cfg_req),
        .commit_ready(commit_ready),
        .done_discard(done_discard),
        .cfg_grant   (cfg_grant)
    );

    // R1
    one_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_valid & ~$past(inj_valid) & ~{NPORTS{squash}}) || !$past(push_valid) || $past(fill_valid) || $past(squash));
endmodule

// File: tb/array_ingress_test.sv
module array_ingress_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4, DEPTH = 8, DW = 16, MAXI = 8;
    localparam int DESTW = $clog2(NP);

    logic clk = 1'b0, rst_n = 1'b0;
    logic push_valid = 0, push_mem = 0, fill_valid = 0, squash = 0;
    logic commit = 0, done = 0, cfg_req = 0;
    logic [DESTW-1:0] push_dest = '0, fill_dest = '0;
    logic [DW-1:0] push_data = '0, fill_data = '0;
    logic [NP-1:0] credit = '0;
    logic [NP-1:0] push_ready, inj_valid, inj_kill;
    logic [NP*DW-1:0] inj_data;
    logic commit_ready, done_discard, cfg_grant;

    array_ingress #(.NPORTS(NP), .DEPTH(DEPTH), .DW(DW), .MAX_INV(MAXI)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_dest(push_dest),
        .push_mem(push_mem), .push_data(push_data), .push_ready(push_ready),
        .fill_valid(fill_valid), .fill_dest(fill_dest), .fill_data(fill_data),
        .squash(squash), .credit(credit), .inj_valid(inj_valid), .inj_kill(inj_kill),
        .inj_data(inj_data), .commit(commit), .commit_ready(commit_ready),
        .done(done), .done_discard(done_discard), .cfg_req(cfg_req), .cfg_grant(cfg_grant));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench model: shift queues, head at index 0.
    int  mq_d [NP][DEPTH];
    bit  mq_b [NP][DEPTH];
    bit  mq_k [NP][DEPTH];
    int  mq_n [NP];
    int  m_infl, m_abort;
    int  total = 0, failed = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_valid(input int p);
        return mq_n[p] > 0 && !mq_b[p][0];
    endfunction

    function automatic int first_busy(input int p);
        for (int i = 0; i < mq_n[p]; i++) if (mq_b[p][i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) mq_n[p] = 0;
        m_infl = 0; m_abort = 0;
    endtask

    // Drive one cycle, check outputs before the edge, then advance the model.
    task automatic step(input bit pv, input int pd, input bit pm, input int pdat,
                        input bit fv, input int fd, input int fdat, input bit sq,
                        input logic [NP-1:0] cr, input bit cm, input bit dn, input bit cf);
        bit acc, de, disc, pop;
        int fb, nf;
        @(negedge clk);
        push_valid = pv; push_dest = DESTW'(pd); push_mem = pm; push_data = DW'(pdat);
        fill_valid = fv; fill_dest = DESTW'(fd); fill_data = DW'(fdat); squash = sq;
        credit = cr; commit = cm; done = dn; cfg_req = cf;
        #1;
        for (int p = 0; p < NP; p++) begin
            chk(inj_valid[p] == exp_valid(p), "R3/R5 inj_valid", inj_valid[p], exp_valid(p));
            chk(push_ready[p] == (mq_n[p] < DEPTH), "R6 push_ready", push_ready[p], mq_n[p] < DEPTH);
            if (exp_valid(p)) begin
                chk(inj_kill[p] == mq_k[p][0], "R7 inj_kill", inj_kill[p], mq_k[p][0]);
                if (!mq_k[p][0])
                    chk(int'(inj_data[p*DW +: DW]) == mq_d[p][0], "R1/R2/R4 inj_data",
                        int'(inj_data[p*DW +: DW]), mq_d[p][0]);
            end
        end
        chk(commit_ready == (m_infl < MAXI), "R8 commit_ready", commit_ready, m_infl < MAXI);
        chk(cfg_grant == (cf && m_infl == 0), "R9 cfg_grant", cfg_grant, cf && m_infl == 0);
        acc  = cm && m_infl < MAXI;
        de   = dn && m_infl > 0;
        disc = de && m_abort > 0;
        chk(done_discard == disc, "R10 done_discard", done_discard, disc);
        // queue model update
        for (int p = 0; p < NP; p++) begin
            pop = exp_valid(p) && cr[p];
            if (sq) begin
                for (int i = 0; i < mq_n[p]; i++) begin mq_b[p][i] = 0; mq_k[p][i] = 1; end
            end else if (fv && fd == p) begin
                fb = first_busy(p);
                if (fb >= 0) begin mq_b[p][fb] = 0; mq_d[p][fb] = fdat & 32'hFFFF; end
            end
            nf = mq_n[p];
            if (pop) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    mq_d[p][i] = mq_d[p][i+1]; mq_b[p][i] = mq_b[p][i+1]; mq_k[p][i] = mq_k[p][i+1];
                end
                mq_n[p]--;
            end
            if (pv && pd == p && nf < DEPTH) begin
                mq_d[p][mq_n[p]] = pm ? 0 : (pdat & 32'hFFFF);
                mq_b[p][mq_n[p]] = pm;
                mq_k[p][mq_n[p]] = 0;
                mq_n[p]++;
            end
        end
        m_infl = m_infl + int'(acc) - int'(de);
        if (sq) m_abort = m_infl;
        else if (disc) m_abort--;
    endtask

    task automatic idle(input logic [NP-1:0] cr);
        step(0, 0, 0, 0, 0, 0, 0, 0, cr, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failed++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R11: state right after reset
        #1;
        chk(push_ready == '1, "R11 push_ready after reset", push_ready, 15);
        chk(inj_valid == '0, "R11 inj_valid after reset", inj_valid, 0);
        chk(commit_ready == 1'b1, "R11 commit_ready after reset", commit_ready, 1);
        idle('0);

        // R3/R4: mem, reg, mem on port 2 with credit; busy head blocks
        step(1, 2, 1, 0, 0, 0, 0, 0, '0, 0, 0, 0);
        step(1, 2, 0, 16'h1111, 0, 0, 0, 0, '0, 0, 0, 0);
        step(1, 2, 1, 0, 0, 0, 0, 0, '0, 0, 0, 0);
        idle(4'b0100); idle(4'b0100);
        // R7: fill to a port with no busy entry is ignored
        step(0, 0, 0, 0, 1, 3, 16'hDEAD, 0, '0, 0, 0, 0);
        idle(4'b1000);
        step(0, 0, 0, 0, 1, 2, 16'hAAAA, 0, '0, 0, 0, 0);  // R4 oldest busy
        idle(4'b0100); idle(4'b0100); idle(4'b0100);
        step(0, 0, 0, 0, 1, 2, 16'hBBBB, 0, '0, 0, 0, 0);
        idle(4'b0100); idle(4'b0100);

        // R6: overfill port 1 with no credit
        for (int i = 0; i < DEPTH + 3; i++) step(1, 1, 0, 100 + i, 0, 0, 0, 0, '0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) idle(4'b0010);  // R2 order out

        // R8/R9/R10: commit past limit, squash, drain completions
        for (int i = 0; i < MAXI + 2; i++) step(0, 0, 0, 0, 0, 0, 0, 0, '0, 1, 0, 1);
        step(1, 0, 1, 0, 0, 0, 0, 0, '0, 0, 1, 1);
        step(1, 0, 1, 0, 1, 0, 7, 1, '0, 1, 0, 0);  // R7 squash with fill ignored
        step(0, 0, 0, 0, 1, 0, 9, 0, '0, 0, 0, 0);
        idle(4'b0001); idle(4'b0001); idle(4'b0001);
        for (int i = 0; i < MAXI + 2; i++) step(0, 0, 0, 0, 0, 0, 0, 0, '0, (i == 3), 1, 1);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            step(($urandom % 4) != 0, $urandom % NP, ($urandom % 3) == 0, $urandom,
                 ($urandom % 3) == 0, $urandom % NP, $urandom, ($urandom % 97) == 0,
                 NP'($urandom & $urandom), ($urandom % 5) == 0, ($urandom % 6) == 0,
                 ($urandom % 4) == 0);
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule